// File: doc/BRIEF.md
# Two-Wide Register Renaming Unit

This block renames a pair of decoded instructions every cycle before they enter a reorder buffer. Each instruction names at most one destination and two source operands. A source operand is either an architectural register or an immediate. Every destination receives a fresh tag. Tags come from a counter that starts at 1 and only counts upward, and no tag is ever recycled. A map table remembers, for each architectural register, the tag of its youngest writer. A source that reads a register with a live writer is replaced by that tag. A source that reads a register with no writer is forwarded as the register number. Immediates are copied through unchanged.

Slot 0 is older than slot 1 in program order. When slot 1 reads the register that slot 0 writes in the same group, slot 1 picks up slot 0's new tag and not the older entry in the table. The renamed pair is registered and appears one cycle after it is accepted. A stall from the reorder buffer freezes the outputs, the table and the tag counter. While the stall is high, the presented inputs are not consumed.

Top module: `rnm_rename2`

## Requirements
- R1: After reset `out_vld_o` is 0, every architectural register reads as unrenamed, and the first destination tag handed out is 1.
- R2: Destination tags are allocated in program order, slot 0 before slot 1, each one greater than the previous allocation. Only a valid slot with `in_dst_en_i` set consumes a tag.
- R3: A register source whose register has been written by an earlier renamed instruction comes out with kind 2 (tag) and the tag of the youngest such writer in the low bits of its value.
- R4: A register source whose register has no renamed writer comes out with kind 1 (architectural) and the register number, taken from the low `$clog2(NUM_AREGS)` bits of the source field. Kind 3 never appears on a valid slot.
- R5: A source with its `_reg_i` bit low is an immediate. It comes out with kind 0 and its full `OPND_W`-bit value unchanged, even if its low bits match a renamed register.
- R6: When slot 1 reads the register written by slot 0 of the same group, the slot 1 source carries slot 0's new tag.
- R7: When both slots of a group write the same register, later readers see slot 1's tag.
- R8: A source that names the instruction's own destination register resolves to the mapping that existed before that instruction.
- R9: While `stall_i` is high, all outputs hold their values and the inputs are ignored. No tag is consumed and the map table does not change.
- R10: A group accepted at a clock edge with `stall_i` low appears on the outputs right after that edge. `out_vld_o` mirrors `in_vld_i`, and an invalid slot allocates nothing.

## Ports
Slot `s` of each packed field occupies bits `[s*W +: W]`. Here W is the field width: AW = `$clog2(NUM_AREGS)`, OW = `OPND_W`, TW = `TAG_W`, and 2 for kinds.

| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stall_i | input | 1 | Reorder buffer back-pressure; freezes the block |
| in_vld_i | input | 2 | Slot valid |
| in_dst_en_i | input | 2 | Slot has a destination |
| in_dst_i | input | 2*AW | Destination register per slot |
| in_s1_reg_i | input | 2 | Source 1 is a register (1) or immediate (0) |
| in_s1_i | input | 2*OW | Source 1 register number or immediate |
| in_s2_reg_i | input | 2 | Source 2 is a register (1) or immediate (0) |
| in_s2_i | input | 2*OW | Source 2 register number or immediate |
| out_vld_o | output | 2 | Renamed slot valid |
| out_dst_en_o | output | 2 | Renamed slot carries a destination tag |
| out_dst_tag_o | output | 2*TW | Allocated destination tag |
| out_s1_kind_o | output | 4 | Source 1 kind: 0 imm, 1 arch, 2 tag |
| out_s1_o | output | 2*OW | Source 1 value |
| out_s2_kind_o | output | 4 | Source 2 kind |
| out_s2_o | output | 2*OW | Source 2 value |

## Verification
A wrong map entry stays hidden until a later instruction reads that register. At that point the register shows up as the wrong tag, or as an architectural name where a tag belongs, one cycle after the read is accepted. A tag counter that skips or repeats a value shows up on the very next destination allocation. A missed intra-group forward or a wrong winner on a same-register pair is exposed only by a dependent read in the same group, or in the group right after. So the directed sequences always pair each write with an immediate read-back.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  typedef enum logic [1:0] {
    OPK_IMM  = 2'd0,
    OPK_ARCH = 2'd1,
    OPK_TAG  = 2'd2
  } opnd_kind_e;

  function automatic int opnd_width(input int aw, input int tw, input int iw);
    int m;
    m = (aw > tw) ? aw : tw;
    return (iw > m) ? iw : m;
  endfunction
endpackage

// File: rtl/rnm_map_table.sv
module rnm_map_table #(
  parameter int NUM_AREGS = 32,
  parameter int TAG_W     = 8,
  parameter int NUM_RD    = 4,
  localparam int AW       = $clog2(NUM_AREGS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [1:0]            we_i,
  input  logic [2*AW-1:0]       wa_i,
  input  logic [2*TAG_W-1:0]    wt_i,
  input  logic [NUM_RD*AW-1:0]  ra_i,
  output logic [NUM_RD-1:0]     rv_o,
  output logic [NUM_RD*TAG_W-1:0] rt_o
);
  logic             vld_q [NUM_AREGS];
  logic [TAG_W-1:0] tag_q [NUM_AREGS];

  for (genvar e = 0; e < NUM_AREGS; e++) begin : g_ent
    logic hit0, hit1;
    assign hit0 = we_i[0] && (wa_i[0 +: AW] == AW'(e));
    assign hit1 = we_i[1] && (wa_i[AW +: AW] == AW'(e));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[e] <= 1'b0;
        tag_q[e] <= '0;
      end else if (hit1) begin  // younger slot wins
        vld_q[e] <= 1'b1;
        tag_q[e] <= wt_i[TAG_W +: TAG_W];
      end else if (hit0) begin
        vld_q[e] <= 1'b1;
        tag_q[e] <= wt_i[0 +: TAG_W];
      end
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    assign rv_o[r]               = vld_q[ra_i[r*AW +: AW]];
    assign rt_o[r*TAG_W +: TAG_W] = tag_q[ra_i[r*AW +: AW]];
  end
endmodule

// File: rtl/rnm_tag_alloc.sv
module rnm_tag_alloc #(
  parameter int TAG_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               adv_i,
  input  logic [1:0]         req_i,
  output logic [2*TAG_W-1:0] tag_o
);
  logic [TAG_W-1:0] next_q;

  assign tag_o[0 +: TAG_W]     = next_q;
  assign tag_o[TAG_W +: TAG_W] = next_q + TAG_W'(req_i[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    next_q <= TAG_W'(1);
    else if (adv_i) next_q <= next_q + TAG_W'(req_i[0]) + TAG_W'(req_i[1]);
  end
endmodule

// File: rtl/rnm_src_resolve.sv
module rnm_src_resolve
  import rnm_pkg::*;
#(
  parameter int AW    = 5,
  parameter int TAG_W = 8,
  parameter int OW    = 16
) (
  input  logic             is_reg_i,
  input  logic [OW-1:0]    val_i,
  input  logic             map_vld_i,
  input  logic [TAG_W-1:0] map_tag_i,
  input  logic             byp_en_i,
  input  logic [AW-1:0]    byp_reg_i,
  input  logic [TAG_W-1:0] byp_tag_i,
  output opnd_kind_e       kind_o,
  output logic [OW-1:0]    val_o
);
  logic [AW-1:0] areg;
  assign areg = val_i[AW-1:0];

  always_comb begin
    if (!is_reg_i) begin
      kind_o = OPK_IMM;
      val_o  = val_i;
    end else if (byp_en_i && (byp_reg_i == areg)) begin
      kind_o = OPK_TAG;
      val_o  = OW'(byp_tag_i);
    end else if (map_vld_i) begin
      kind_o = OPK_TAG;
      val_o  = OW'(map_tag_i);
    end else begin
      kind_o = OPK_ARCH;
      val_o  = OW'(areg);
    end
  end
endmodule

// File: rtl/rnm_rename2.sv
module rnm_rename2
  import rnm_pkg::*;
#(
  parameter int NUM_AREGS = 32,
  parameter int TAG_W     = 8,
  parameter int IMM_W     = 16,
  localparam int AW       = $clog2(NUM_AREGS),
  localparam int OPND_W   = opnd_width(AW, TAG_W, IMM_W)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  stall_i,
  input  logic [1:0]            in_vld_i,
  input  logic [1:0]            in_dst_en_i,
  input  logic [2*AW-1:0]       in_dst_i,
  input  logic [1:0]            in_s1_reg_i,
  input  logic [2*OPND_W-1:0]   in_s1_i,
  input  logic [1:0]            in_s2_reg_i,
  input  logic [2*OPND_W-1:0]   in_s2_i,
  output logic [1:0]            out_vld_o,
  output logic [1:0]            out_dst_en_o,
  output logic [2*TAG_W-1:0]    out_dst_tag_o,
  output logic [3:0]            out_s1_kind_o,
  output logic [2*OPND_W-1:0]   out_s1_o,
  output logic [3:0]            out_s2_kind_o,
  output logic [2*OPND_W-1:0]   out_s2_o
);
  localparam int OW = OPND_W;

  logic [1:0]          alloc_req;
  logic [1:0]          map_we;
  logic [2*TAG_W-1:0]  new_tag;
  logic [4*AW-1:0]     rd_addr;
  logic [3:0]          rd_vld;
  logic [4*TAG_W-1:0]  rd_tag;
  logic [3:0]          nxt_kind;
  logic [2*OW-1:0]     nxt_s1, nxt_s2;

  assign alloc_req = in_vld_i & in_dst_en_i;
  assign map_we    = alloc_req & {2{~stall_i}};

  rnm_tag_alloc #(.TAG_W(TAG_W)) u_alloc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (~stall_i),
    .req_i (alloc_req),
    .tag_o (new_tag)
  );

  rnm_map_table #(.NUM_AREGS(NUM_AREGS), .TAG_W(TAG_W), .NUM_RD(4)) u_map (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (map_we),
    .wa_i  (in_dst_i),
    .wt_i  (new_tag),
    .ra_i  (rd_addr),
    .rv_o  (rd_vld),
    .rt_o  (rd_tag)
  );

  for (genvar s = 0; s < 2; s++) begin : g_slot
    opnd_kind_e k1, k2;
    logic       byp_en;
    // only the younger slot sees the older slot's fresh tag
    assign byp_en = (s == 1) ? alloc_req[0] : 1'b0;

    assign rd_addr[(2*s)*AW +: AW]   = in_s1_i[s*OW +: AW];
    assign rd_addr[(2*s+1)*AW +: AW] = in_s2_i[s*OW +: AW];

    rnm_src_resolve #(.AW(AW), .TAG_W(TAG_W), .OW(OW)) u_s1 (
      .is_reg_i (in_s1_reg_i[s]),
      .val_i    (in_s1_i[s*OW +: OW]),
      .map_vld_i(rd_vld[2*s]),
      .map_tag_i(rd_tag[(2*s)*TAG_W +: TAG_W]),
      .byp_en_i (byp_en),
      .byp_reg_i(in_dst_i[0 +: AW]),
      .byp_tag_i(new_tag[0 +: TAG_W]),
      .kind_o   (k1),
      .val_o    (nxt_s1[s*OW +: OW])
    );

    rnm_src_resolve #(.AW(AW), .TAG_W(TAG_W), .OW(OW)) u_s2 (
      .is_reg_i (in_s2_reg_i[s]),
      .val_i    (in_s2_i[s*OW +: OW]),
      .map_vld_i(rd_vld[2*s+1]),
      .map_tag_i(rd_tag[(2*s+1)*TAG_W +: TAG_W]),
      .byp_en_i (byp_en),
      .byp_reg_i(in_dst_i[0 +: AW]),
      .byp_tag_i(new_tag[0 +: TAG_W]),
      .kind_o   (k2),
      .val_o    (nxt_s2[s*OW +: OW])
    );

    assign nxt_kind[s]   = 1'b0;
    assign nxt_kind[s+2] = 1'b0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_s1_kind_o[2*s +: 2] <= 2'd0;
        out_s2_kind_o[2*s +: 2] <= 2'd0;
      end else if (!stall_i) begin
        out_s1_kind_o[2*s +: 2] <= k1;
        out_s2_kind_o[2*s +: 2] <= k2;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o     <= '0;
      out_dst_en_o  <= '0;
      out_dst_tag_o <= '0;
      out_s1_o      <= '0;
      out_s2_o      <= '0;
    end else if (!stall_i) begin
      out_vld_o     <= in_vld_i;
      out_dst_en_o  <= alloc_req;
      out_dst_tag_o <= new_tag;
      out_s1_o      <= nxt_s1;
      out_s2_o      <= nxt_s2;
    end
  end

  logic unused_ok;
  assign unused_ok = ^nxt_kind;
endmodule

// File: rtl/rnm_rename2_chk.sv
module rnm_rename2_chk #(
  parameter int AW = 5,
  parameter int TW = 8,
  parameter int OW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stall_i,
  input logic [1:0]    in_vld_i,
  input logic [1:0]    in_dst_en_i,
  input logic [2*AW-1:0] in_dst_i,
  input logic [1:0]    in_s1_reg_i,
  input logic [2*OW-1:0] in_s1_i,
  input logic [1:0]    in_s2_reg_i,
  input logic [2*OW-1:0] in_s2_i,
  input logic [1:0]    out_vld_o,
  input logic [1:0]    out_dst_en_o,
  input logic [2*TW-1:0] out_dst_tag_o,
  input logic [3:0]    out_s1_kind_o,
  input logic [2*OW-1:0] out_s1_o,
  input logic [3:0]    out_s2_kind_o,
  input logic [2*OW-1:0] out_s2_o
);
  logic [TW-1:0] chk_next_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_next_q <= TW'(1);
    else if (!stall_i)
      chk_next_q <= chk_next_q + TW'($countones(in_vld_i & in_dst_en_i));
  end

  assert_slot0_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && in_vld_i[0] && in_dst_en_i[0]) |=> out_dst_tag_o[0 +: TW] == $past(chk_next_q));

  assert_pair_tag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o == 2'b11 && out_dst_en_o == 2'b11) |->
      out_dst_tag_o[TW +: TW] == out_dst_tag_o[0 +: TW] + TW'(1));

  assert_kind_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o[0] |-> (out_s1_kind_o[1:0] != 2'd3 && out_s2_kind_o[1:0] != 2'd3));

  assert_kind_legal1_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o[1] |-> (out_s1_kind_o[3:2] != 2'd3 && out_s2_kind_o[3:2] != 2'd3));

  assert_imm_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && in_vld_i[0] && !in_s2_reg_i[0]) |=>
      (out_s2_kind_o[1:0] == 2'd0 && out_s2_o[0 +: OW] == $past(in_s2_i[0 +: OW])));

  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && in_vld_i == 2'b11 && in_dst_en_i[0] && in_s1_reg_i[1] &&
     in_s1_i[OW +: AW] == in_dst_i[0 +: AW]) |=>
      (out_s1_kind_o[3:2] == 2'd2 && out_s1_o[OW +: OW] == OW'(out_dst_tag_o[0 +: TW])));

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(out_vld_o) && $stable(out_dst_en_o) && $stable(out_dst_tag_o) &&
                 $stable(out_s1_kind_o) && $stable(out_s1_o) &&
                 $stable(out_s2_kind_o) && $stable(out_s2_o)));

  assert_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> out_vld_o == $past(in_vld_i));
endmodule

bind rnm_rename2 rnm_rename2_chk #(.AW(AW), .TW(TAG_W), .OW(OPND_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stall_i      (stall_i),
  .in_vld_i     (in_vld_i),
  .in_dst_en_i  (in_dst_en_i),
  .in_dst_i     (in_dst_i),
  .in_s1_reg_i  (in_s1_reg_i),
  .in_s1_i      (in_s1_i),
  .in_s2_reg_i  (in_s2_reg_i),
  .in_s2_i      (in_s2_i),
  .out_vld_o    (out_vld_o),
  .out_dst_en_o (out_dst_en_o),
  .out_dst_tag_o(out_dst_tag_o),
  .out_s1_kind_o(out_s1_kind_o),
  .out_s1_o     (out_s1_o),
  .out_s2_kind_o(out_s2_kind_o),
  .out_s2_o     (out_s2_o)
);

// File: tb/rnm_rename2_test.sv
module rnm_rename2_test;
  localparam int NA = 32;
  localparam int AW = 5;
  localparam int TW = 8;
  localparam int OW = 16;

  typedef struct {
    bit vld; bit den; int dst;
    bit r1; int v1; bit r2; int v2;
  } ins_t;

  logic clk_i = 1'b0;
  always #5 clk_i = ~clk_i;

  logic rst_ni, stall_i;
  logic [1:0] in_vld_i, in_dst_en_i, in_s1_reg_i, in_s2_reg_i;
  logic [2*AW-1:0] in_dst_i;
  logic [2*OW-1:0] in_s1_i, in_s2_i;
  logic [1:0] out_vld_o, out_dst_en_o;
  logic [2*TW-1:0] out_dst_tag_o;
  logic [3:0] out_s1_kind_o, out_s2_kind_o;
  logic [2*OW-1:0] out_s1_o, out_s2_o;

  rnm_rename2 #(.NUM_AREGS(NA), .TAG_W(TW), .IMM_W(OW)) uut (
    .clk_i, .rst_ni, .stall_i, .in_vld_i, .in_dst_en_i, .in_dst_i,
    .in_s1_reg_i, .in_s1_i, .in_s2_reg_i, .in_s2_i,
    .out_vld_o, .out_dst_en_o, .out_dst_tag_o,
    .out_s1_kind_o, .out_s1_o, .out_s2_kind_o, .out_s2_o
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int m_vld[NA], m_tag[NA], m_next;
  int e_vld[2], e_den[2], e_tag[2], e_k1[2], e_v1[2], e_k2[2], e_v2[2];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic ins_t op(int d, bit r1, int v1, bit r2, int v2);
    ins_t x;
    x.vld = 1; x.den = 1; x.dst = d; x.r1 = r1; x.v1 = v1; x.r2 = r2; x.v2 = v2;
    return x;
  endfunction

  function automatic ins_t nop();
    ins_t x;
    x.vld = 0; x.den = 0; x.dst = 0; x.r1 = 0; x.v1 = 0; x.r2 = 0; x.v2 = 0;
    return x;
  endfunction

  // sequential model: slot 0 fully renamed before slot 1 looks
  function automatic void resolve(bit r, int v, output int k, output int val);
    if (!r) begin k = 0; val = v & 16'hffff; end
    else if (m_vld[v & (NA-1)] != 0) begin k = 2; val = m_tag[v & (NA-1)]; end
    else begin k = 1; val = v & (NA-1); end
  endfunction

  task automatic drive(ins_t a, ins_t b);
    in_vld_i    = {b.vld, a.vld};
    in_dst_en_i = {b.den, a.den};
    in_dst_i    = {AW'(b.dst), AW'(a.dst)};
    in_s1_reg_i = {b.r1, a.r1};
    in_s2_reg_i = {b.r2, a.r2};
    in_s1_i     = {OW'(b.v1), OW'(a.v1)};
    in_s2_i     = {OW'(b.v2), OW'(a.v2)};
  endtask

  task automatic compare(string req);
    for (int s = 0; s < 2; s++) begin
      chk(req, "vld", int'(out_vld_o[s]), e_vld[s]);
      if (e_vld[s] != 0) begin
        chk(req, "dst_en", int'(out_dst_en_o[s]), e_den[s]);
        if (e_den[s] != 0) chk(req, "dst_tag", int'(out_dst_tag_o[s*TW +: TW]), e_tag[s]);
        chk(req, "s1_kind", int'(out_s1_kind_o[2*s +: 2]), e_k1[s]);
        chk(req, "s1_val",  int'(out_s1_o[s*OW +: OW]), e_v1[s]);
        chk(req, "s2_kind", int'(out_s2_kind_o[2*s +: 2]), e_k2[s]);
        chk(req, "s2_val",  int'(out_s2_o[s*OW +: OW]), e_v2[s]);
      end
    end
  endtask

  task automatic issue(ins_t a, ins_t b, string req);
    ins_t x;
    @(negedge clk_i);
    stall_i = 0;
    drive(a, b);
    for (int s = 0; s < 2; s++) begin
      x = (s == 0) ? a : b;
      e_vld[s] = x.vld;
      e_den[s] = (x.vld && x.den) ? 1 : 0;
      if (x.vld) begin
        resolve(x.r1, x.v1, e_k1[s], e_v1[s]);
        resolve(x.r2, x.v2, e_k2[s], e_v2[s]);
        if (x.den) begin
          e_tag[s] = m_next;
          m_next++;
          m_vld[x.dst] = 1;
          m_tag[x.dst] = e_tag[s];
        end
      end
    end
    @(posedge clk_i); #1;
    in_vld_i = 2'b00;
    compare(req);
  endtask

  localparam int R2r = 2, R3r = 3;
  localparam int F1 = 17, F2 = 18, F3 = 19, F4 = 20, F5 = 21, F6 = 22;

  task automatic t_reset();
    rst_ni = 0; stall_i = 0;
    drive(nop(), nop());
    for (int i = 0; i < NA; i++) begin m_vld[i] = 0; m_tag[i] = 0; end
    m_next = 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    chk("R1", "out_vld after reset", int'(out_vld_o), 0);
  endtask

  task automatic t_first_group();
    // both sources unrenamed, immediates on s2
    issue(op(F2, 1, R2r, 0, 0), op(F3, 1, R3r, 0, 0), "R4");
    chk("R1", "first tag", int'(out_dst_tag_o[0 +: TW]), 1);
    chk("R1", "first s1 kind arch", int'(out_s1_kind_o[1:0]), 1);
    chk("R2", "second tag", int'(out_dst_tag_o[TW +: TW]), 2);
  endtask

  task automatic t_program();
    issue(op(F4, 1, F2, 1, F3), op(F2, 1, R2r, 0, 4), "R3");
    chk("R3", "FMUL src1 tag", int'(out_s1_o[0 +: OW]), 1);
    chk("R3", "FMUL src2 tag", int'(out_s2_o[0 +: OW]), 2);
    issue(op(F3, 1, R3r, 0, 4), op(F5, 1, F2, 1, F3), "R6");
    chk("R6", "bypass F3 tag", int'(out_s2_o[OW +: OW]), 5);
    issue(op(F6, 1, F4, 1, F5), op(F4, 1, F4, 1, F5), "R8");
    chk("R8", "own-dst read keeps old tag", int'(out_s1_o[OW +: OW]), 3);
    issue(op(F6, 1, F4, 1, F5), op(F1, 1, F1, 1, F6), "R6");
    chk("R6", "F6 bypass", int'(out_s2_o[OW +: OW]), 9);
    chk("R4", "F1 unrenamed", int'(out_s1_kind_o[3:2]), 1);
  endtask

  task automatic t_same_dst();
    issue(op(5, 1, 6, 1, 7), op(5, 1, 8, 0, 3), "R7");
    issue(op(9, 1, 5, 0, 0), op(10, 1, 5, 1, 5), "R7");
    chk("R7", "reader sees slot1 tag", int'(out_s1_o[0 +: OW]), 12);
  endtask

  task automatic t_self_read();
    issue(op(R2r, 1, R2r, 0, 8), nop(), "R8");
    issue(op(R2r, 1, R2r, 0, 8), op(R3r, 1, R3r, 0, 8), "R8");
  endtask

  task automatic t_imm();
    // immediate whose low bits equal a renamed register
    issue(op(6, 0, 16'hBEEF, 0, F2), op(7, 0, 16'h8012, 1, F2), "R5");
    chk("R5", "imm kind", int'(out_s1_kind_o[1:0]), 0);
    chk("R5", "imm value", int'(out_s1_o[OW +: OW]), 16'h8012);
  endtask

  task automatic t_single_slot();
    issue(nop(), op(11, 1, 6, 0, 1), "R10");
    chk("R10", "slot0 invalid", int'(out_vld_o), 2);
    issue(op(12, 1, 11, 0, 0), nop(), "R2");
  endtask

  task automatic t_stall();
    logic [1:0] sv; logic [2*TW-1:0] st; logic [2*OW-1:0] s1, s2; logic [3:0] k1, k2;
    issue(op(13, 1, 14, 0, 1), op(14, 1, 13, 0, 2), "R6");
    sv = out_vld_o; st = out_dst_tag_o; s1 = out_s1_o; s2 = out_s2_o;
    k1 = out_s1_kind_o; k2 = out_s2_kind_o;
    @(negedge clk_i);
    stall_i = 1;
    drive(op(25, 1, 13, 0, 0), op(26, 1, 14, 0, 0));
    repeat (3) @(posedge clk_i);
    #1;
    chk("R9", "vld held", int'(out_vld_o), int'(sv));
    chk("R9", "tags held", int'(out_dst_tag_o), int'(st));
    chk("R9", "s1 held", int'(out_s1_o), int'(s1));
    chk("R9", "s2 held", int'(out_s2_o), int'(s2));
    chk("R9", "kinds held", int'({k1, k2}), int'({out_s1_kind_o, out_s2_kind_o}));
    @(negedge clk_i);
    stall_i = 0; in_vld_i = 2'b00;
    @(posedge clk_i); #1;
    chk("R10", "idle after stall", int'(out_vld_o), 0);
    // 25/26 must still be unrenamed and no tag consumed
    issue(op(27, 1, 25, 1, 26), nop(), "R9");
  endtask

  initial begin
    t_reset();
    t_first_group();
    t_program();
    t_same_dst();
    t_self_read();
    t_imm();
    t_single_slot();
    t_stall();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule